// File: doc/BRIEF.md
# Pipelined Cascadable Even-Parity Checker

This block sits beside a registered command/address bus. It checks even parity over the bus bits that the parity covers. The parity bit for a word arrives one clock after the word itself. Results come out a fixed number of cycles later on two pins:

- `ppo`, the partial-parity bit: the XOR of the covered bits and the parity input.
- `err_n`, an active-low error flag. After each detected error it stays low for a programmable number of cycles.

Two chip-select inputs, both active low, qualify each word. A word whose selects are both high produces no result. The parity outputs then keep their previous values, and the word cannot raise an error.

Two instances can be chained to cover a wider bus. The head device sends its partial parity out one cycle early. The tail device takes that bit on its own parity input, two cycles after its data. The tail device still produces its result at the standard latency. The position in the chain is set by a static two-bit mode input.

Top module: `par_chain_check`

## Requirements
- R1: A synchronous active-high `rst` drives `ppo` to 0 and `err_n` to 1 on the next clock edge. This includes the case where `err_n` is being held low by an earlier error.
- R2: Standalone mode is `chain_mode` 2'b00, and 2'b01 behaves the same way. A word is on `din` in cycle k and its parity bit is on `par_in` in cycle k+1. In cycle k+3, `ppo` equals the XOR of all `din` bits and that parity bit.
- R3: In standalone and tail modes, a live result with `ppo` 1 (odd total) drives `err_n` low in the same cycle that result appears. A result with `ppo` 0 does not start an error.
- R4: An isolated error holds `err_n` low for exactly HOLD_CYCLES cycles (default 2), after which it returns high.
- R5: An error detected while `err_n` is already low restarts the hold. Errors in consecutive words keep `err_n` low without a gap.
- R6: A word presented with both `sel_a_n` and `sel_b_n` high is ignored, together with the parity bit that belongs to it. `ppo` keeps its value and no error starts.
- R7: A word is live when at least one of `sel_a_n` or `sel_b_n` is low.
- R8: Head mode is `chain_mode` 2'b10. The word is in cycle k and its parity in cycle k+1. In cycle k+2, `ppo` shows the XOR of the word bits and the parity bit.
- R9: Tail mode is `chain_mode` 2'b11. The word is in cycle k and `par_in` carries the upstream partial parity in cycle k+2. In cycle k+3, `ppo` equals the XOR of the word bits and that upstream bit, and R3 applies to that result.
- R10: Words can be presented back to back, one per cycle. Each result pairs a word with its own parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chain_mode | input | 2 | 00/01 standalone, 10 chain head, 11 chain tail |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| din | input | DATA_W | Covered bus bits for the current word |
| par_in | input | 1 | Parity bit, or the upstream partial parity in tail mode |
| ppo | output | 1 | Partial parity out |
| err_n | output | 1 | Stretched parity error flag, active low |

## Verification
The hardest situations to reach are those where the error hold interacts with later events. These are: a second error landing while the flag is still low, a reset arriving in the middle of the hold, and odd-parity words hidden behind a deselect. Each of these needs the parity stream to be offset against the data stream by exactly the right number of cycles.

The bench drives streams of words with per-word masks. One mask marks words whose parity is deliberately wrong, one marks fully deselected words, and one marks words that use only one select. The masks are placed so that errors land one cycle apart, two cycles apart, inside deselected slots, and just before a reset that cuts into the hold.

// File: rtl/ppipe_pkg.sv
package ppipe_pkg;

    // position of this instance in a (possible) chain of two
    typedef enum logic [1:0] {
        CHAIN_SOLO     = 2'b00,
        CHAIN_SOLO_ALT = 2'b01,
        CHAIN_HEAD     = 2'b10,
        CHAIN_TAIL     = 2'b11
    } chain_mode_e;

    // one pipeline slot: a live flag and the running parity sum
    typedef struct packed {
        logic live;
        logic sum;
    } slot_t;

    // parity bit is folded in at the second stage for every mode but tail
    function automatic logic joins_early(chain_mode_e m);
        return (m != CHAIN_TAIL);
    endfunction

    // the head device exposes its partial sum one stage early
    function automatic logic emits_early(chain_mode_e m);
        return (m == CHAIN_HEAD);
    endfunction

    function automatic logic is_live(logic a_n, logic b_n);
        return !(a_n && b_n);
    endfunction

endpackage

// File: rtl/pp_fold.sv
module pp_fold #(
    parameter int WIDTH  = 22,
    parameter int LANE_W = 8
) (
    input  logic [WIDTH-1:0] word,
    output logic             odd
);
    localparam int LANES = (WIDTH + LANE_W - 1) / LANE_W;
    localparam int PAD_W = LANES * LANE_W;

    logic [PAD_W-1:0] padded;
    logic [LANES-1:0] lane_odd;

    assign padded = PAD_W'(word);

    // each lane reduces a slice, the lanes are then combined
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_odd[g] = ^padded[g*LANE_W +: LANE_W];
    end

    assign odd = ^lane_odd;
endmodule

// File: rtl/pp_capture.sv
module pp_capture
    import ppipe_pkg::*;
#(
    parameter int WIDTH  = 22,
    parameter int LANE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_a_n,
    input  logic             sel_b_n,
    input  logic [WIDTH-1:0] word,
    output slot_t            slot
);
    logic word_odd;

    pp_fold #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_fold (
        .word (word),
        .odd  (word_odd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else begin
            slot.live <= is_live(sel_a_n, sel_b_n);
            slot.sum  <= word_odd;
        end
    end

    p_select_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!sel_a_n || !sel_b_n) |=> slot.live);

    p_desel_dead_r6: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n && sel_b_n) |=> !slot.live);
endmodule

// File: rtl/pp_merge.sv
module pp_merge
    import ppipe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  join_now,
    input  logic  par_in,
    input  slot_t slot_in,
    output slot_t slot_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_out <= '0;
        end else begin
            slot_out.live <= slot_in.live;
            if (slot_in.live)
                slot_out.sum <= slot_in.sum ^ (join_now & par_in);
        end
    end

    p_dead_slot_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !slot_in.live |=> $stable(slot_out.sum));
endmodule

// File: rtl/pp_result.sv
module pp_result
    import ppipe_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  join_now,
    input  logic  par_in,
    input  slot_t slot_in,
    output logic  ppo_q,
    output logic  err_n
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] hold_cnt;
    logic          total_odd;

    assign total_odd = slot_in.sum ^ (join_now & par_in);
    assign err_n     = (hold_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ppo_q    <= 1'b0;
            hold_cnt <= '0;
        end else begin
            if (slot_in.live)
                ppo_q <= total_odd;
            if (slot_in.live && total_odd)
                hold_cnt <= CW'(HOLD_CYCLES);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - CW'(1);
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (ppo_q == 1'b0 && err_n));

    p_error_pulls_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ppo_q) |-> !err_n);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= CW'(HOLD_CYCLES));

    p_dead_result_r6: assert property (@(posedge clk) disable iff (rst)
        !slot_in.live |=> $stable(ppo_q));

    if (HOLD_CYCLES >= 2) begin : g_stretch_chk
        p_stretch_r4: assert property (@(posedge clk) disable iff (rst)
            $fell(err_n) |=> !err_n);
    end
endmodule

// File: rtl/par_chain_check.sv
module par_chain_check
    import ppipe_pkg::*;
#(
    parameter int DATA_W      = 22,
    parameter int LANE_W      = 8,
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        chain_mode,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic [DATA_W-1:0] din,
    input  logic              par_in,
    output logic              ppo,
    output logic              err_n
);
    chain_mode_e mode;
    slot_t       s1;
    slot_t       s2;
    logic        ppo_q;
    logic        join_mid;
    logic        join_end;

    assign mode     = chain_mode_e'(chain_mode);
    assign join_mid = joins_early(mode);
    assign join_end = !joins_early(mode);

    pp_capture #(.WIDTH(DATA_W), .LANE_W(LANE_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .sel_a_n (sel_a_n),
        .sel_b_n (sel_b_n),
        .word    (din),
        .slot    (s1)
    );

    pp_merge u_mrg (
        .clk      (clk),
        .rst      (rst),
        .join_now (join_mid),
        .par_in   (par_in),
        .slot_in  (s1),
        .slot_out (s2)
    );

    pp_result #(.HOLD_CYCLES(HOLD_CYCLES)) u_res (
        .clk      (clk),
        .rst      (rst),
        .join_now (join_end),
        .par_in   (par_in),
        .slot_in  (s2),
        .ppo_q    (ppo_q),
        .err_n    (err_n)
    );

    assign ppo = emits_early(mode) ? s2.sum : ppo_q;

    p_head_reset_r1: assert property (@(posedge clk)
        rst |=> !ppo);
endmodule

// File: tb/sim_par_chain_check.sv
module sim_par_chain_check;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 22;
    localparam int HOLD       = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        chain_mode = 2'b00;
    logic              sel_a_n = 1'b1;
    logic              sel_b_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic              par_in = 1'b0;
    logic              ppo;
    logic              err_n;

    par_chain_check #(.DATA_W(DATA_W), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst(rst), .chain_mode(chain_mode),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .din(din),
        .par_in(par_in), .ppo(ppo), .err_n(err_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int at;
        bit live;
        bit odd;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    fails = 0;
    bit    chk_err = 1'b1;
    bit    done = 1'b0;
    string tag_ppo = "R2";
    string tag_err = "R3";
    bit    exp_ppo = 1'b0;
    int    exp_cnt = 0;

    task automatic note(input bit ok, input string tag, input string what,
                        input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [DATA_W-1:0] mkword(input int s);
        logic [31:0] x;
        x = s * 32'h9E3779B1;
        x = x ^ 32'h5A5A1234;
        x = x ^ (x >> 13);
        return x[DATA_W-1:0];
    endfunction

    // monitor: pops expected results at their cycle and compares
    always @(negedge clk) begin
        exp_t it;
        if (rst) begin
            note(ppo === 1'b0, "R1", "ppo in reset", int'(ppo), 0);
            note(err_n === 1'b1, "R1", "err_n in reset", int'(err_n), 1);
            sb.delete();
            exp_ppo = 1'b0;
            exp_cnt = 0;
        end else begin
            if (exp_cnt > 0) exp_cnt--;
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                it = sb.pop_front();
                if (it.at == cyc && it.live) begin
                    exp_ppo = it.odd;
                    if (it.odd) exp_cnt = HOLD;
                end
            end
            note(ppo === exp_ppo, tag_ppo, "ppo", int'(ppo), int'(exp_ppo));
            if (chk_err)
                note(err_n === (exp_cnt == 0), tag_err, "err_n",
                     int'(err_n), int'(exp_cnt == 0));
        end
    end

    // driver: words in cycle i, parity lat_par cycles later, expectation pushed
    task automatic stream(input int n, input int lat_par, input int lat_out,
                          input int tail, input logic [31:0] bad,
                          input logic [31:0] off, input logic [31:0] half,
                          input int seed);
        bit pq[32];
        for (int i = 0; i < n + tail; i++) begin
            logic [DATA_W-1:0] w;
            exp_t e;
            @(negedge clk);
            #1;
            if (i < n) begin
                w = mkword(seed + i);
                din = w;
                pq[i] = (^w) ^ bad[i];
                if (off[i])       {sel_a_n, sel_b_n} = 2'b11;
                else if (half[i]) {sel_a_n, sel_b_n} = i[0] ? 2'b01 : 2'b10;
                else              {sel_a_n, sel_b_n} = 2'b00;
                e.at = cyc + lat_out;
                e.live = !off[i];
                e.odd = bad[i];
                sb.push_back(e);
            end else begin
                din = mkword(seed + 100 + i);
                {sel_a_n, sel_b_n} = 2'b11;
            end
            if (i >= lat_par && i - lat_par < n) par_in = pq[i - lat_par];
            else par_in = 1'b1;
        end
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        #1;
        rst = 1'b1;
        chain_mode = m;
        {sel_a_n, sel_b_n} = 2'b11;
        repeat (2) @(negedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst = 1'b0;

        tag_ppo = "R2"; tag_err = "R3";
        stream(16, 1, 3, 6, 32'h0000_0A49, 32'h0, 32'h0, 11);

        tag_ppo = "R10"; tag_err = "R10";
        stream(12, 1, 3, 6, 32'h0, 32'h0, 32'h0, 37);

        tag_ppo = "R4"; tag_err = "R4";
        stream(8, 1, 3, 6, 32'h0000_0008, 32'h0, 32'h0, 59);

        tag_ppo = "R5"; tag_err = "R5";
        stream(14, 1, 3, 6, 32'h0000_0A66, 32'h0, 32'h0, 71);

        tag_ppo = "R6"; tag_err = "R6";
        stream(12, 1, 3, 6, 32'h0000_00B1, 32'h0000_00F0, 32'h0, 83);

        tag_ppo = "R7"; tag_err = "R7";
        stream(12, 1, 3, 6, 32'h0000_0124, 32'h0, 32'h0000_0FFF, 97);

        do_reset(2'b01);
        tag_ppo = "R2"; tag_err = "R3";
        stream(10, 1, 3, 6, 32'h0000_0052, 32'h0, 32'h0, 113);

        do_reset(2'b10);
        chk_err = 1'b0;
        tag_ppo = "R8"; tag_err = "R8";
        stream(12, 1, 2, 6, 32'h0000_0013, 32'h0000_0040, 32'h0, 131);

        do_reset(2'b11);
        chk_err = 1'b1;
        tag_ppo = "R9"; tag_err = "R9";
        stream(12, 2, 3, 6, 32'h0000_0329, 32'h0000_0004, 32'h0, 149);

        // reset lands while the flag is being held low
        do_reset(2'b00);
        tag_ppo = "R1"; tag_err = "R1";
        stream(1, 1, 3, 2, 32'h1, 32'h0, 32'h0, 167);
        do_reset(2'b00);

        repeat (4) @(negedge clk);
        #1;
        note(sb.size() == 0, "R10", "pending results", sb.size(), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule